// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle 32-bit processor whose datapath (program counter, instruction register, scratch registers x, y and z, register file, ALU and a shared memory port) lives elsewhere. Each instruction passes through a short walk of control states. Every state drives the full set of datapath control lines: PC write and PC source, the instruction/data address select, memory read and write, instruction-register load, register-file write with its destination and input source, the two ALU operand selects, the ALU function, and the cause/EPC writes used on exceptions.

The opcode and function fields come from the instruction register, which holds them stable for the whole instruction. The ALU zero flag, ALU result bit 31 and the overflow flag come back from the datapath, and a separate input marks an opcode as illegal. Outputs depend on the present state and on the held instruction fields. The single exception is the PC-write qualification in the jump/branch state, which also follows the ALU flags of that cycle. An arithmetic overflow or an unrecognised instruction sends the machine to one of two exception states. These record a cause bit, save the PC and redirect the PC to the system-routine address.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: An active-low reset, asserted at any time, puts the machine at once in the fetch state (`state_o` = 0) with the fetch outputs of R2.
- R2: Fetch (state 0) drives mem_read=1, ir_write=1, inst_data=0, alu_src_x=0, alu_src_y=0 (constant 4), add_sub=0, fn_class=2 (arithmetic), pc_src=3 and pc_write=1, and always moves to decode (state 1). Decode drives alu_src_x=0, alu_src_y=3 (4×imm) and an add, with every write strobe low.
- R3: From decode the machine goes to state 10 when the instruction is illegal, otherwise to state 5 for j (op 2), jal (3), bltz (1), beq (4), bne (5) and R-type (op 0) jr (fn 8) or syscall (fn 12), to state 2 for lw (35) or sw (43), and to state 7 for the ALU instructions: lui (15), addi (8), slti (10), andi (12), ori (13), xori (14) and R-type add (32), sub (34), slt (42), and (36), or (37), xor (38), nor (39).
- R4: State 2 drives alu_src_x=1, alu_src_y=2 with an add, then goes to state 3 for lw or state 6 for sw. State 3 drives inst_data=1 and mem_read=1 and goes to state 4. State 4 writes the register file with reg_dst=0 (rt) and reg_in_src=0 (data register). State 6 drives inst_data=1 and mem_write=1.
- R5: State 7 drives alu_src_x=1. It drives alu_src_y=2 for immediate-form instructions and 1 (y register) for R-type. fn_class is 0 for lui, 1 for slt/slti, 2 for add/sub/addi and 3 for the logic group. add_sub=1 for sub, slt and slti. logic_fn is 0 AND, 1 OR, 2 XOR, 3 NOR.
- R6: State 8 writes the register file with reg_in_src=1 (z register). reg_dst is 1 (rd) for R-type and 0 (rt) for immediate forms.
- R7: State 5 drives alu_src_x=1, alu_src_y=1 and a subtract. jump_addr_sel is 1 only for syscall. pc_src is 0 for j, jal and syscall, 1 for jr, and 2 for the branches.
- R8: In state 5, pc_write is 1 for every jump. For beq it equals the ALU zero flag, for bne its inverse, and for bltz ALU result bit 31.
- R9: For jal, state 5 also writes the register file with reg_dst=2 (link register) and reg_in_src=1.
- R10: An overflow flag seen in state 7 sends the machine to state 9 instead of state 8. State 9 drives cause_write=1, int_cause=1, epc_write=1, jump_addr_sel=1, pc_src=0 and pc_write=1.
- R11: An instruction is illegal when the illegal input is high, when the opcode is not one listed in R3, or when an R-type function code is not one listed in R3. State 10 drives the outputs of state 9 but with int_cause=0.
- R12: States 4, 5, 6, 8, 9 and 10 are followed by fetch. mem_read and mem_write are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 6 | Opcode field from the instruction register |
| fn | input | 6 | Function field from the instruction register |
| alu_zero | input | 1 | ALU result is zero |
| alu_msb | input | 1 | ALU result bit 31 |
| alu_ovfl | input | 1 | ALU overflow |
| illegal_op | input | 1 | External illegal-instruction mark |
| pc_write | output | 1 | Load the PC |
| pc_src | output | 2 | PC source: 0 jump address, 1 x reg, 2 z reg, 3 ALU out |
| jump_addr_sel | output | 1 | Jump address: 0 target field, 1 system routine |
| inst_data | output | 1 | Memory address: 0 PC, 1 z reg |
| mem_read | output | 1 | Memory read |
| mem_write | output | 1 | Memory write |
| ir_write | output | 1 | Load the instruction register |
| reg_write | output | 1 | Register file write |
| reg_dst | output | 2 | Destination: 0 rt, 1 rd, 2 link register |
| reg_in_src | output | 1 | Write data: 0 data reg, 1 z reg |
| alu_src_x | output | 1 | ALU X: 0 PC, 1 x reg |
| alu_src_y | output | 2 | ALU Y: 0 const 4, 1 y reg, 2 imm, 3 4×imm |
| add_sub | output | 1 | 0 add, 1 subtract |
| logic_fn | output | 2 | Logic function |
| fn_class | output | 2 | Function class |
| cause_write | output | 1 | Load the cause register |
| int_cause | output | 1 | Cause value: 1 overflow, 0 illegal |
| epc_write | output | 1 | Save the PC into EPC |
| state_o | output | 4 | Present control state number |

## Verification
Every output is decoded from the present state, so a wrong state shows up on the control lines in the same cycle the machine enters it. Typical symptoms are a write strobe in the wrong cycle, a missing mem_read, or a PC load with the wrong source, and `state_o` exposes the state directly. A wrong dispatch from decode becomes visible one cycle after decode. A lost return to fetch shows up one cycle after the terminal state, when ir_write fails to rise. Each instruction class is therefore compared cycle by cycle against its expected state walk and control pattern.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int OP_W = 6;
  localparam int FN_W = 6;
  localparam int ST_W = 4;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LOAD   = 4'd3,
    ST_LOADWB = 4'd4,
    ST_XFER   = 4'd5,
    ST_STORE  = 4'd6,
    ST_EXEC   = 4'd7,
    ST_ALUWB  = 4'd8,
    ST_OVF    = 4'd9,
    ST_ILL    = 4'd10
  } mc_state_e;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'd0;
  localparam logic [OP_W-1:0] OP_BLTZ  = 6'd1;
  localparam logic [OP_W-1:0] OP_J     = 6'd2;
  localparam logic [OP_W-1:0] OP_JAL   = 6'd3;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'd4;
  localparam logic [OP_W-1:0] OP_BNE   = 6'd5;
  localparam logic [OP_W-1:0] OP_ADDI  = 6'd8;
  localparam logic [OP_W-1:0] OP_SLTI  = 6'd10;
  localparam logic [OP_W-1:0] OP_ANDI  = 6'd12;
  localparam logic [OP_W-1:0] OP_ORI   = 6'd13;
  localparam logic [OP_W-1:0] OP_XORI  = 6'd14;
  localparam logic [OP_W-1:0] OP_LUI   = 6'd15;
  localparam logic [OP_W-1:0] OP_LW    = 6'd35;
  localparam logic [OP_W-1:0] OP_SW    = 6'd43;

  localparam logic [FN_W-1:0] FN_JR  = 6'd8;
  localparam logic [FN_W-1:0] FN_SYS = 6'd12;
  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_OR  = 6'd37;
  localparam logic [FN_W-1:0] FN_XOR = 6'd38;
  localparam logic [FN_W-1:0] FN_NOR = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

  localparam logic [1:0] FC_LUI   = 2'd0;
  localparam logic [1:0] FC_SLT   = 2'd1;
  localparam logic [1:0] FC_ARITH = 2'd2;
  localparam logic [1:0] FC_LOGIC = 2'd3;

  localparam logic [1:0] BR_NONE = 2'd0;
  localparam logic [1:0] BR_EQ   = 2'd1;
  localparam logic [1:0] BR_NE   = 2'd2;
  localparam logic [1:0] BR_LTZ  = 2'd3;

  typedef struct packed {
    logic       valid;
    logic       is_rtype;
    logic       is_imm;
    logic       is_mem;
    logic       is_load;
    logic       is_xfer;
    logic       is_jr;
    logic       is_sys;
    logic       is_jal;
    logic [1:0] br;
    logic       sub;
    logic [1:0] fclass;
    logic [1:0] lfn;
  } mc_inst_t;

  typedef struct packed {
    logic       pc_write;
    logic [1:0] pc_src;
    logic       jump_sel;
    logic       inst_data;
    logic       mem_read;
    logic       mem_write;
    logic       ir_write;
    logic       reg_write;
    logic [1:0] reg_dst;
    logic       reg_in_src;
    logic       src_x;
    logic [1:0] src_y;
    logic       add_sub;
    logic [1:0] logic_fn;
    logic [1:0] fn_class;
    logic       cause_write;
    logic       int_cause;
    logic       epc_write;
  } mc_ctrl_t;

  // Branch qualification: unconditional transfers always load the PC.
  function automatic logic branch_taken(input logic [1:0] br,
                                        input logic zero,
                                        input logic msb);
    case (br)
      BR_EQ:   return zero;
      BR_NE:   return ~zero;
      BR_LTZ:  return msb;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/mc_inst_decode.sv
module mc_inst_decode
  import mc_ctrl_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [FN_W-1:0] fn,
  output mc_inst_t        inst
);
  always_comb begin
    inst       = '0;
    inst.valid = 1'b1;
    inst.fclass = FC_ARITH;
    case (op)
      OP_RTYPE: begin
        inst.is_rtype = 1'b1;
        case (fn)
          FN_ADD: inst.fclass = FC_ARITH;
          FN_SUB: inst.sub = 1'b1;
          FN_SLT: begin inst.sub = 1'b1; inst.fclass = FC_SLT; end
          FN_AND: begin inst.fclass = FC_LOGIC; inst.lfn = 2'd0; end
          FN_OR:  begin inst.fclass = FC_LOGIC; inst.lfn = 2'd1; end
          FN_XOR: begin inst.fclass = FC_LOGIC; inst.lfn = 2'd2; end
          FN_NOR: begin inst.fclass = FC_LOGIC; inst.lfn = 2'd3; end
          FN_JR:  begin inst.is_xfer = 1'b1; inst.is_jr = 1'b1; end
          FN_SYS: begin inst.is_xfer = 1'b1; inst.is_sys = 1'b1; end
          default: inst.valid = 1'b0;
        endcase
      end
      OP_LUI:  begin inst.is_imm = 1'b1; inst.fclass = FC_LUI; end
      OP_ADDI: inst.is_imm = 1'b1;
      OP_SLTI: begin inst.is_imm = 1'b1; inst.sub = 1'b1; inst.fclass = FC_SLT; end
      OP_ANDI: begin inst.is_imm = 1'b1; inst.fclass = FC_LOGIC; inst.lfn = 2'd0; end
      OP_ORI:  begin inst.is_imm = 1'b1; inst.fclass = FC_LOGIC; inst.lfn = 2'd1; end
      OP_XORI: begin inst.is_imm = 1'b1; inst.fclass = FC_LOGIC; inst.lfn = 2'd2; end
      OP_LW:   begin inst.is_mem = 1'b1; inst.is_load = 1'b1; end
      OP_SW:   inst.is_mem = 1'b1;
      OP_J:    inst.is_xfer = 1'b1;
      OP_JAL:  begin inst.is_xfer = 1'b1; inst.is_jal = 1'b1; end
      OP_BLTZ: begin inst.is_xfer = 1'b1; inst.br = BR_LTZ; end
      OP_BEQ:  begin inst.is_xfer = 1'b1; inst.br = BR_EQ; end
      OP_BNE:  begin inst.is_xfer = 1'b1; inst.br = BR_NE; end
      default: inst.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  mc_state_e st,
  input  mc_inst_t  inst,
  input  logic      illegal,
  input  logic      ovfl,
  output mc_state_e nxt
);
  always_comb begin
    case (st)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (illegal)           nxt = ST_ILL;
        else if (inst.is_xfer) nxt = ST_XFER;
        else if (inst.is_mem)  nxt = ST_ADDR;
        else                   nxt = ST_EXEC;
      end
      ST_ADDR:   nxt = inst.is_load ? ST_LOAD : ST_STORE;
      ST_LOAD:   nxt = ST_LOADWB;
      ST_EXEC:   nxt = ovfl ? ST_OVF : ST_ALUWB;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_out_decode.sv
module mc_out_decode
  import mc_ctrl_pkg::*;
(
  input  mc_state_e st,
  input  mc_inst_t  inst,
  input  logic      zero,
  input  logic      msb,
  output mc_ctrl_t  c
);
  always_comb begin
    c          = '0;
    c.fn_class = FC_ARITH;
    case (st)
      ST_FETCH: begin
        c.mem_read = 1'b1;
        c.ir_write = 1'b1;
        c.pc_src   = 2'd3;
        c.pc_write = 1'b1;
      end
      ST_DECODE: c.src_y = 2'd3;
      ST_ADDR: begin
        c.src_x = 1'b1;
        c.src_y = 2'd2;
      end
      ST_LOAD: begin
        c.inst_data = 1'b1;
        c.mem_read  = 1'b1;
      end
      ST_LOADWB: c.reg_write = 1'b1;
      ST_XFER: begin
        c.src_x    = 1'b1;
        c.src_y    = 2'd1;
        c.add_sub  = 1'b1;
        c.jump_sel = inst.is_sys;
        c.pc_src   = inst.is_jr ? 2'd1 : ((inst.br != BR_NONE) ? 2'd2 : 2'd0);
        c.pc_write = branch_taken(inst.br, zero, msb);
        if (inst.is_jal) begin
          c.reg_write  = 1'b1;
          c.reg_dst    = 2'd2;
          c.reg_in_src = 1'b1;
        end
      end
      ST_STORE: begin
        c.inst_data = 1'b1;
        c.mem_write = 1'b1;
      end
      ST_EXEC: begin
        c.src_x    = 1'b1;
        c.src_y    = inst.is_imm ? 2'd2 : 2'd1;
        c.add_sub  = inst.sub;
        c.fn_class = inst.fclass;
        c.logic_fn = inst.lfn;
      end
      ST_ALUWB: begin
        c.reg_write  = 1'b1;
        c.reg_dst    = inst.is_rtype ? 2'd1 : 2'd0;
        c.reg_in_src = 1'b1;
      end
      ST_OVF, ST_ILL: begin
        c.cause_write = 1'b1;
        c.epc_write   = 1'b1;
        c.int_cause   = (st == ST_OVF);
        c.jump_sel    = 1'b1;
        c.pc_src      = 2'd0;
        c.pc_write    = 1'b1;
      end
      default: c.fn_class = FC_ARITH;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op,
  input  logic [FN_W-1:0] fn,
  input  logic            alu_zero,
  input  logic            alu_msb,
  input  logic            alu_ovfl,
  input  logic            illegal_op,
  output logic            pc_write,
  output logic [1:0]      pc_src,
  output logic            jump_addr_sel,
  output logic            inst_data,
  output logic            mem_read,
  output logic            mem_write,
  output logic            ir_write,
  output logic            reg_write,
  output logic [1:0]      reg_dst,
  output logic            reg_in_src,
  output logic            alu_src_x,
  output logic [1:0]      alu_src_y,
  output logic            add_sub,
  output logic [1:0]      logic_fn,
  output logic [1:0]      fn_class,
  output logic            cause_write,
  output logic            int_cause,
  output logic            epc_write,
  output logic [ST_W-1:0] state_o
);
  mc_state_e state_q, state_d;
  mc_inst_t  inst;
  mc_ctrl_t  ctrl;
  logic      illegal;

  mc_inst_decode u_dec (.op(op), .fn(fn), .inst(inst));

  assign illegal = illegal_op | ~inst.valid;

  mc_next_state u_nxt (
    .st(state_q), .inst(inst), .illegal(illegal), .ovfl(alu_ovfl), .nxt(state_d)
  );

  mc_out_decode u_out (
    .st(state_q), .inst(inst), .zero(alu_zero), .msb(alu_msb), .c(ctrl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign pc_write      = ctrl.pc_write;
  assign pc_src        = ctrl.pc_src;
  assign jump_addr_sel = ctrl.jump_sel;
  assign inst_data     = ctrl.inst_data;
  assign mem_read      = ctrl.mem_read;
  assign mem_write     = ctrl.mem_write;
  assign ir_write      = ctrl.ir_write;
  assign reg_write     = ctrl.reg_write;
  assign reg_dst       = ctrl.reg_dst;
  assign reg_in_src    = ctrl.reg_in_src;
  assign alu_src_x     = ctrl.src_x;
  assign alu_src_y     = ctrl.src_y;
  assign add_sub       = ctrl.add_sub;
  assign logic_fn      = ctrl.logic_fn;
  assign fn_class      = ctrl.fn_class;
  assign cause_write   = ctrl.cause_write;
  assign int_cause     = ctrl.int_cause;
  assign epc_write     = ctrl.epc_write;
  assign state_o       = state_q;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alu_ovfl,
  input logic [3:0] state_o,
  input logic       mem_read,
  input logic       mem_write,
  input logic       cause_write,
  input logic       epc_write,
  input logic       pc_write,
  input logic [1:0] pc_src,
  input logic       jump_addr_sel,
  input logic       ir_write
);
  logic terminal;
  assign terminal = (state_o == 4'd4) || (state_o == 4'd5) || (state_o == 4'd6) ||
                    (state_o == 4'd8) || (state_o == 4'd9) || (state_o == 4'd10);

  a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd0) |=> (state_o == 4'd1));

  a_r12_back_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    terminal |=> (state_o == 4'd0 && ir_write));

  a_r10_ovfl_divert: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd7 && alu_ovfl) |=> (state_o == 4'd9));

  a_r4_load_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd3) |=> (state_o == 4'd4));

  a_r12_mem_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_read && mem_write));

  a_r11_cause_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    cause_write |-> (epc_write && pc_write && pc_src == 2'd0 && jump_addr_sel));
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .alu_ovfl(alu_ovfl), .state_o(state_o),
  .mem_read(mem_read), .mem_write(mem_write), .cause_write(cause_write),
  .epc_write(epc_write), .pc_write(pc_write), .pc_src(pc_src),
  .jump_addr_sel(jump_addr_sel), .ir_write(ir_write)
);

// File: tb/tb_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module tb_mc_ctrl_fsm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] op = '0, fn = '0;
  logic alu_zero = 0, alu_msb = 0, alu_ovfl = 0, illegal_op = 0;
  logic pc_write, jump_addr_sel, inst_data, mem_read, mem_write, ir_write, reg_write;
  logic reg_in_src, alu_src_x, add_sub, cause_write, int_cause, epc_write;
  logic [1:0] pc_src, reg_dst, alu_src_y, logic_fn, fn_class;
  logic [3:0] state_o;

  int n_vec = 0, n_bad = 0;
  logic [27:0] exp_q[$];
  string       tag_q[$];

  // bench-side view of the instruction being run
  int e_kind; // 0 alu, 1 load, 2 store, 3 transfer, 4 illegal
  bit e_imm, e_rt, e_sub, e_jr, e_sys, e_jal;
  int e_br;   // 0 none, 1 eq, 2 ne, 3 ltz
  logic [1:0] e_fc, e_lf;

  always #4 clk = ~clk;

  mc_ctrl_fsm dut (.*);

  function automatic logic [27:0] actual();
    return {state_o, pc_write, pc_src, jump_addr_sel, inst_data, mem_read, mem_write,
            ir_write, reg_write, reg_dst, reg_in_src, alu_src_x, alu_src_y, add_sub,
            logic_fn, fn_class, cause_write, int_cause, epc_write};
  endfunction

  function automatic logic [27:0] expect_in(input int st);
    logic pcw = 0, ja = 0, id = 0, mr = 0, mw = 0, irw = 0, rw = 0, ris = 0, sx = 0, as = 0;
    logic cw = 0, ic = 0, ew = 0;
    logic [1:0] pcs = 0, rd = 0, sy = 0, lf = 0, fc = 2'd2;
    case (st)
      0: begin mr = 1; irw = 1; pcs = 3; pcw = 1; end
      1: sy = 3;
      2: begin sx = 1; sy = 2; end
      3: begin id = 1; mr = 1; end
      4: rw = 1;
      5: begin
        sx = 1; sy = 1; as = 1; ja = e_sys;
        if (e_jr) pcs = 1; else if (e_br != 0) pcs = 2;
        case (e_br)
          1: pcw = alu_zero;
          2: pcw = !alu_zero;
          3: pcw = alu_msb;
          default: pcw = 1;
        endcase
        if (e_jal) begin rw = 1; rd = 2; ris = 1; end
      end
      6: begin id = 1; mw = 1; end
      7: begin sx = 1; sy = e_imm ? 2'd2 : 2'd1; as = e_sub; fc = e_fc; lf = e_lf; end
      8: begin rw = 1; rd = e_rt ? 2'd1 : 2'd0; ris = 1; end
      default: begin cw = 1; ew = 1; ja = 1; pcw = 1; ic = (st == 9); end
    endcase
    return {st[3:0], pcw, pcs, ja, id, mr, mw, irw, rw, rd, ris, sx, sy, as, lf, fc, cw, ic, ew};
  endfunction

  function automatic string tag_of(input int st);
    case (st)
      0: return "R2/R12";
      1: return "R2";
      2, 3, 4, 6: return "R4";
      5: return e_jal ? "R9" : (e_br != 0 ? "R8" : "R7");
      7: return "R5";
      8: return "R6";
      9: return "R10";
      default: return "R11";
    endcase
  endfunction

  // driver: called at a falling edge while the machine is in fetch
  task automatic run_instr(input string nm, input logic [5:0] o, input logic [5:0] f,
                           input bit z, input bit m, input bit ov, input bit il);
    int path[$];
    e_kind = 0; e_imm = 0; e_rt = 0; e_sub = 0; e_jr = 0; e_sys = 0; e_jal = 0;
    e_br = 0; e_fc = 2'd2; e_lf = 2'd0;
    case (nm)
      "add":  e_rt = 1;
      "sub":  begin e_rt = 1; e_sub = 1; end
      "slt":  begin e_rt = 1; e_sub = 1; e_fc = 1; end
      "and":  begin e_rt = 1; e_fc = 3; e_lf = 0; end
      "or":   begin e_rt = 1; e_fc = 3; e_lf = 1; end
      "xor":  begin e_rt = 1; e_fc = 3; e_lf = 2; end
      "nor":  begin e_rt = 1; e_fc = 3; e_lf = 3; end
      "lui":  begin e_imm = 1; e_fc = 0; end
      "addi": e_imm = 1;
      "slti": begin e_imm = 1; e_sub = 1; e_fc = 1; end
      "andi": begin e_imm = 1; e_fc = 3; e_lf = 0; end
      "ori":  begin e_imm = 1; e_fc = 3; e_lf = 1; end
      "xori": begin e_imm = 1; e_fc = 3; e_lf = 2; end
      "lw":   e_kind = 1;
      "sw":   e_kind = 2;
      "j":    e_kind = 3;
      "jal":  begin e_kind = 3; e_jal = 1; end
      "jr":   begin e_kind = 3; e_jr = 1; end
      "syscall": begin e_kind = 3; e_sys = 1; end
      "beq":  begin e_kind = 3; e_br = 1; end
      "bne":  begin e_kind = 3; e_br = 2; end
      "bltz": begin e_kind = 3; e_br = 3; end
      default: e_kind = 4;
    endcase
    if (il) e_kind = 4;
    op = o; fn = f; alu_zero = z; alu_msb = m; alu_ovfl = ov; illegal_op = il;
    path = {0, 1};
    case (e_kind)
      0: path = {path, 7, ov ? 9 : 8};
      1: path = {path, 2, 3, 4};
      2: path = {path, 2, 6};
      3: path = {path, 5};
      default: path = {path, 10};
    endcase
    foreach (path[i]) begin
      exp_q.push_back(expect_in(path[i]));
      tag_q.push_back(i == 2 ? {"R3/", tag_of(path[i]), " ", nm} : {tag_of(path[i]), " ", nm});
    end
    repeat (path.size()) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [27:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_vec++;
        if (actual() !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, actual(), e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    n_vec++;
    if (actual() !== expect_in(0)) begin
      n_bad++;
      $display("FAIL R1 reset: actual %h expected %h", actual(), expect_in(0));
    end
    @(negedge clk);
    rst_n = 1'b1;
    run_instr("add",  6'd0,  6'd32, 0, 0, 0, 0);
    run_instr("sub",  6'd0,  6'd34, 0, 0, 0, 0);
    run_instr("slt",  6'd0,  6'd42, 0, 0, 0, 0);
    run_instr("and",  6'd0,  6'd36, 0, 0, 0, 0);
    run_instr("or",   6'd0,  6'd37, 0, 0, 0, 0);
    run_instr("xor",  6'd0,  6'd38, 0, 0, 0, 0);
    run_instr("nor",  6'd0,  6'd39, 0, 0, 0, 0);
    run_instr("lui",  6'd15, 6'd0,  0, 0, 0, 0);
    run_instr("addi", 6'd8,  6'd5,  0, 0, 0, 0);
    run_instr("slti", 6'd10, 6'd0,  0, 0, 0, 0);
    run_instr("andi", 6'd12, 6'd0,  0, 0, 0, 0);
    run_instr("ori",  6'd13, 6'd0,  0, 0, 0, 0);
    run_instr("xori", 6'd14, 6'd0,  0, 0, 0, 0);
    run_instr("lw",   6'd35, 6'd0,  0, 0, 0, 0);
    run_instr("sw",   6'd43, 6'd0,  0, 0, 0, 0);
    run_instr("j",    6'd2,  6'd0,  0, 0, 0, 0);
    run_instr("jal",  6'd3,  6'd0,  0, 0, 0, 0);
    run_instr("jr",   6'd0,  6'd8,  0, 0, 0, 0);
    run_instr("syscall", 6'd0, 6'd12, 0, 0, 0, 0);
    run_instr("beq",  6'd4,  6'd0,  1, 0, 0, 0);
    run_instr("beq",  6'd4,  6'd0,  0, 1, 0, 0);
    run_instr("bne",  6'd5,  6'd0,  1, 0, 0, 0);
    run_instr("bne",  6'd5,  6'd0,  0, 0, 0, 0);
    run_instr("bltz", 6'd1,  6'd0,  0, 1, 0, 0);
    run_instr("bltz", 6'd1,  6'd0,  1, 0, 0, 0);
    run_instr("j",    6'd2,  6'd0,  0, 0, 1, 0);  // overflow ignored outside execute
    run_instr("add",  6'd0,  6'd32, 0, 0, 1, 0);  // R10 overflow
    run_instr("addi", 6'd8,  6'd0,  0, 1, 1, 0);  // R10 overflow, immediate form
    run_instr("bad",  6'd63, 6'd0,  0, 0, 0, 0);  // R11 unknown opcode
    run_instr("bad",  6'd0,  6'd1,  0, 0, 0, 0);  // R11 unknown function code
    run_instr("add",  6'd0,  6'd32, 0, 0, 0, 1);  // R11 external mark
    run_instr("lw",   6'd35, 6'd0,  0, 0, 0, 0);
    // R1: reset in the middle of an instruction
    op = 6'd0; fn = 6'd32; alu_ovfl = 0; illegal_op = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    n_vec++;
    if (actual() !== expect_in(0)) begin
      n_bad++;
      $display("FAIL R1 mid-run reset: actual %h expected %h", actual(), expect_in(0));
    end
    @(negedge clk);
    rst_n = 1'b1;
    run_instr("sw",   6'd43, 6'd0,  0, 0, 0, 0);
    @(negedge clk);
    finish_run();
  end
endmodule